// File: doc/BRIEF.md
# DRAM PHY Training Scheduler

This block sequences the training phases of a DRAM PHY from one control word. Software writes the word with the training types it wants and a rank mask for each. If bit 0 is set and no run is in progress, the write starts a run. The scheduler then works through the enabled phases in a fixed order. For each phase it gives the phase's engine a one-cycle start pulse and that phase's rank mask, then waits for the engine's done pulse before going on.

When the last enabled phase finishes, the scheduler sets a read-only completion bit in the same word, and software polls that bit. The word also stores the write-leveling calibration enable and the DVFS and periodic retraining enables. These fields can be read back but have no effect on the sequence. The training algorithms themselves sit in the external engines.

Top module: `phy_train_sched`

## Requirements
- R1: After reset, `reg_rdata` reads 0, `phase_start` is 0 and `phase_rank` is 0.
- R2: A write accepted while idle stores `reg_wdata[23:2]`. Those bits read back at the same positions. Bit 1 of a write is ignored. A write with bit 0 clear starts nothing and leaves the completion bit unchanged.
- R3: Bits [31:24] always read as zero, whatever was written to them.
- R4: A write with bit 0 set while idle accepts a start. In the next cycle, bit 0 reads 1 (busy) and bit 1 reads 0 (completion cleared). The first enabled phase shows its start pulse in that same cycle.
- R5: The phase enables and `phase_start`/`phase_done` indices are: command bus training bit 2 / index 0, write leveling bit 3 / index 1, gate training bit 4 / index 2, read training bit 5 / index 3, write training bit 6 / index 4. Enabled phases run in ascending index order. Disabled phases are skipped. The next enabled phase starts in the cycle after the current phase's done pulse.
- R6: Each phase start is a single-cycle pulse, and at most one start bit is high at a time. While a phase waits, a done pulse on any other index is ignored.
- R7: While a phase is issued or waiting, `phase_rank` carries that phase's rank field: write leveling [9:8], gate [11:10], read [13:12], write [15:14]. For command bus training it carries 2'b11.
- R8: In the cycle after the done pulse of the last enabled phase, bit 1 reads 1 and bit 0 reads 0. The two bits are never both 1.
- R9: A start with bits [6:2] all zero issues no phase start. Bit 0 reads 1 for one cycle, and bit 1 reads 1 in the cycle after that.
- R10: A write that arrives while busy is ignored entirely. The stored fields and the running sequence are unchanged.
- R11: Bit 7 and bits [23:16] are stored and read back, but they do not change which phases run or their timing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Write strobe for the control word |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Control word readback with busy in bit 0 and completion in bit 1 |
| phase_start | output | 5 | One-cycle start pulse per phase, indexed as in R5 |
| phase_rank | output | 2 | Rank mask of the active phase |
| phase_done | input | 5 | Done pulse from each phase engine |

## Verification
The bench drives a write in one cycle and expects busy and the first start pulse in the next cycle. Within a phase, it expects the following start exactly one cycle after the cycle in which it raises the engine's done pulse. It expects completion one cycle after the last done pulse, or two cycles after the write when no phase is enabled. All inputs change at the falling edge, and every output is sampled at the falling edge of the cycle worked out above. During each wait cycle the bench also checks that no start pulse appears and that the rank mask holds its value.

// File: rtl/phy_train_sched_pkg.sv
package phy_train_sched_pkg;
  localparam int NPH      = 5;
  localparam int PH_W     = $clog2(NPH);
  localparam int RANK_W   = 2;
  localparam int EN_LSB   = 2;
  localparam int RANK_LSB = 8;
  localparam int CFG_LSB  = 2;
  localparam int CFG_MSB  = 23;
  localparam int CFG_W    = CFG_MSB - CFG_LSB + 1;
  localparam int RANKS_W  = (NPH - 1) * RANK_W;

  typedef enum logic [1:0] {ST_IDLE, ST_ISSUE, ST_WAIT, ST_FIN} st_e;

  typedef struct packed {
    logic            hit;
    logic [PH_W-1:0] idx;
  } pick_t;

  // lowest enabled phase with index >= from
  function automatic pick_t pick_next(logic [NPH-1:0] en, int from);
    pick_t r;
    r.hit = 1'b0;
    r.idx = '0;
    for (int i = NPH - 1; i >= 0; i--) begin
      if (en[i] && i >= from) begin
        r.hit = 1'b1;
        r.idx = PH_W'(i);
      end
    end
    return r;
  endfunction

  // phase 0 has no rank field and drives every rank
  function automatic logic [RANK_W-1:0] rank_of(logic [RANKS_W-1:0] ranks,
                                                logic [PH_W-1:0] idx);
    logic [RANK_W-1:0] r;
    r = '1;
    for (int i = 1; i < NPH; i++)
      if (int'(idx) == i) r = ranks[(i-1)*RANK_W +: RANK_W];
    return r;
  endfunction
endpackage

// File: rtl/phy_train_sched_cfg.sv
module phy_train_sched_cfg
  import phy_train_sched_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CFG_W-1:0] wfield,
  output logic [31:0]      cfg_word
);
  logic [CFG_W-1:0] store_q;

  always_ff @(posedge clk) begin
    if (!rst_n)    store_q <= '0;
    else if (load) store_q <= wfield;
  end

  assign cfg_word = {{(31-CFG_MSB){1'b0}}, store_q, {CFG_LSB{1'b0}}};
endmodule

// File: rtl/phy_train_sched_seq.sv
module phy_train_sched_seq
  import phy_train_sched_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start_acc,
  input  logic [NPH-1:0]     new_en,
  input  logic [NPH-1:0]     cfg_en,
  input  logic [RANKS_W-1:0] cfg_ranks,
  input  logic [NPH-1:0]     phase_done,
  output logic               busy,
  output logic               done,
  output logic               phase_finish,
  output logic [NPH-1:0]     phase_start,
  output logic [RANK_W-1:0]  phase_rank
);
  st_e             st_q;
  logic [PH_W-1:0] cur_q;
  logic            done_q;
  pick_t           first_pick;
  pick_t           next_pick;

  assign first_pick   = pick_next(new_en, 0);
  assign next_pick    = pick_next(cfg_en, int'(cur_q) + 1);
  assign phase_finish = (st_q == ST_WAIT) && phase_done[cur_q];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      cur_q  <= '0;
      done_q <= 1'b0;
    end else begin
      case (st_q)
        ST_IDLE: if (start_acc) begin
          done_q <= 1'b0;
          if (first_pick.hit) begin
            st_q  <= ST_ISSUE;
            cur_q <= first_pick.idx;
          end else begin
            st_q <= ST_FIN;
          end
        end
        ST_ISSUE: st_q <= ST_WAIT;
        ST_WAIT: if (phase_finish) begin
          if (next_pick.hit) begin
            st_q  <= ST_ISSUE;
            cur_q <= next_pick.idx;
          end else begin
            st_q   <= ST_IDLE;
            done_q <= 1'b1;
          end
        end
        default: begin
          st_q   <= ST_IDLE;
          done_q <= 1'b1;
        end
      endcase
    end
  end

  assign busy        = (st_q != ST_IDLE);
  assign done        = done_q;
  assign phase_start = (st_q == ST_ISSUE) ? (NPH'(1) << cur_q) : '0;
  assign phase_rank  = (st_q == ST_ISSUE || st_q == ST_WAIT) ?
                       rank_of(cfg_ranks, cur_q) : '0;
endmodule

// File: rtl/phy_train_sched.sv
module phy_train_sched
  import phy_train_sched_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  output logic [NPH-1:0]    phase_start,
  output logic [RANK_W-1:0] phase_rank,
  input  logic [NPH-1:0]    phase_done
);
  logic        busy;
  logic        done;
  logic        wr_accept;
  logic        run_launch;
  logic        phase_finish;
  logic [31:0] cfg_word;
  logic        unused_wbits;

  assign wr_accept    = reg_wr && !busy;
  assign run_launch   = wr_accept && reg_wdata[0];
  assign unused_wbits = ^{reg_wdata[31:CFG_MSB+1], reg_wdata[1]};

  phy_train_sched_cfg u_cfg (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (wr_accept),
    .wfield   (reg_wdata[CFG_MSB:CFG_LSB]),
    .cfg_word (cfg_word)
  );

  phy_train_sched_seq u_seq (
    .clk          (clk),
    .rst_n        (rst_n),
    .start_acc    (run_launch),
    .new_en       (reg_wdata[EN_LSB +: NPH]),
    .cfg_en       (cfg_word[EN_LSB +: NPH]),
    .cfg_ranks    (cfg_word[RANK_LSB +: RANKS_W]),
    .phase_done   (phase_done),
    .busy         (busy),
    .done         (done),
    .phase_finish (phase_finish),
    .phase_start  (phase_start),
    .phase_rank   (phase_rank)
  );

  assign reg_rdata = cfg_word | {30'b0, done, busy};
endmodule

// File: rtl/phy_train_sched_chk.sv
module phy_train_sched_chk
  import phy_train_sched_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              reg_wr,
  input logic [31:0]       reg_wdata,
  input logic [31:0]       reg_rdata,
  input logic [NPH-1:0]    phase_start,
  input logic [NPH-1:0]    phase_done,
  input logic              run_launch,
  input logic              phase_finish
);
  assert_start_onehot_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(phase_start));

  assert_start_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_start != '0) |=> (phase_start == '0));

  assert_resv_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rdata[31:24] == 8'h00);

  assert_busy_write_ignored_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rdata[0] && reg_wr) |=> $stable(reg_rdata[23:2]));

  assert_launch_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!reg_rdata[0] && reg_wr && reg_wdata[0]) |=> (reg_rdata[0] && !reg_rdata[1]));

  assert_done_excl_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !(reg_rdata[0] && reg_rdata[1]));

  assert_empty_run_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!reg_rdata[0] && reg_wr && reg_wdata[0] && reg_wdata[6:2] == 5'd0)
    |=> (phase_start == '0) ##1 reg_rdata[1]);

  assert_launch_needs_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    run_launch |-> !reg_rdata[0]);

  assert_finish_has_done_R6: assert property (@(posedge clk) disable iff (!rst_n)
    phase_finish |-> (phase_done != '0));
endmodule

bind phy_train_sched phy_train_sched_chk u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .reg_wr       (reg_wr),
  .reg_wdata    (reg_wdata),
  .reg_rdata    (reg_rdata),
  .phase_start  (phase_start),
  .phase_done   (phase_done),
  .run_launch   (run_launch),
  .phase_finish (phase_finish)
);

// File: tb/tb_phy_train_sched.sv
`timescale 1ns/1ps
module tb_phy_train_sched;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [4:0]  phase_start;
  logic [1:0]  phase_rank;
  logic [4:0]  phase_done = '0;
  int          errors = 0;
  int          checks = 0;

  always #4 clk = ~clk;

  phy_train_sched dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .phase_start(phase_start),
    .phase_rank(phase_rank), .phase_done(phase_done)
  );

  localparam int NV = 7;
  localparam logic [31:0] VCFG [NV] = '{
    32'h0000_E47C, 32'hFF00_B114, 32'h00FF_7868, 32'h0000_C0C0,
    32'h0000_2590, 32'h0000_5504, 32'h00AA_FF80 };
  localparam int VLAT [NV] = '{1, 3, 2, 4, 1, 5, 1};
  localparam bit VSTRAY [NV] = '{0, 1, 1, 1, 0, 0, 0};

  task automatic check(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [1:0] exp_rank(logic [31:0] c, int k);
    if (k == 0) return 2'b11;
    return c[8 + 2*(k-1) +: 2];
  endfunction

  // one full run; poke=1 writes all ones during the first wait
  task automatic run(input logic [31:0] c, input int lat, input bit stray,
                     input bit poke);
    bit any = 0;
    bit poked = 0;
    @(negedge clk);
    reg_wr = 1'b1;
    reg_wdata = c | 32'h1;
    @(negedge clk);
    reg_wr = 1'b0;
    check(reg_rdata[1:0] == 2'b01, "R4 busy set, done cleared", {30'b0, reg_rdata[1:0]}, 32'h1);
    for (int k = 0; k < 5; k++) begin
      if (c[2+k]) begin
        any = 1;
        check(phase_start == 5'(1 << k), "R5 start order", {27'b0, phase_start}, 32'(1 << k));
        check(phase_rank == exp_rank(c, k), "R7 rank mask", {30'b0, phase_rank}, {30'b0, exp_rank(c, k)});
        for (int w = 1; w <= lat; w++) begin
          @(negedge clk);
          reg_wr = 1'b0;
          if (w == lat) phase_done = 5'(1 << k);
          else if (stray && w == 1) phase_done = 5'(1 << ((k + 1) % 5));
          else phase_done = '0;
          if (poke && !poked) begin
            reg_wr = 1'b1;
            reg_wdata = 32'hFFFF_FFFF;
            poked = 1;
          end
          check(phase_start == '0, "R6 single pulse, stray done ignored", {27'b0, phase_start}, 0);
          check(phase_rank == exp_rank(c, k), "R7 rank held", {30'b0, phase_rank}, {30'b0, exp_rank(c, k)});
        end
        @(negedge clk);
        phase_done = '0;
        reg_wr = 1'b0;
      end
    end
    if (!any) begin
      check(phase_start == '0, "R9 no phase started", {27'b0, phase_start}, 0);
      @(negedge clk);
    end
    check(phase_start == '0, "R8 no start after last", {27'b0, phase_start}, 0);
    check(reg_rdata == ((c & 32'h00FF_FFFC) | 32'h2), "R8 R2 R3 R11 done and readback",
          reg_rdata, (c & 32'h00FF_FFFC) | 32'h2);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=%h expected=%h", 32'h0, 32'h1);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check(reg_rdata == 32'h0, "R1 reset rdata", reg_rdata, 0);
    check(phase_start == '0 && phase_rank == '0, "R1 reset outputs", {25'b0, phase_rank, phase_start}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(reg_rdata == 32'h0, "R1 after release", reg_rdata, 0);

    for (int v = 0; v < NV; v++) run(VCFG[v], VLAT[v], VSTRAY[v], 1'b0);

    // R10: write of all ones during a run changes nothing
    run(32'h0000_E47C, 4, 1'b0, 1'b1);

    // R2: idle write without start stores fields, bit1 of write ignored, done kept
    @(negedge clk);
    reg_wr = 1'b1;
    reg_wdata = 32'hAB12_3478;
    @(negedge clk);
    reg_wr = 1'b0;
    check(reg_rdata == 32'h0012_347A, "R2 idle store, no start", reg_rdata, 32'h0012_347A);
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      check(phase_start == '0, "R2 no run without bit0", {27'b0, phase_start}, 0);
    end

    // R9 then restart clears done
    run(32'h0000_0000, 1, 1'b0, 1'b0);
    run(32'h0000_0040, 2, 1'b0, 1'b0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule